// File: doc/BRIEF.md
# Remote Block Copy Message Engine

This block is a hardware message handler for split-phase remote memory copies. It accepts a stream of command messages from the network side and serves each one by itself, with no help from the local processor. A message that deposits data writes a block of words into local memory and then adds one to a completion counter word. A message that fetches data reads a local block and answers with a fully formed deposit message. That answer fills the requester's buffer and adds one to the requester's counter.

Each message runs to completion before the next one is taken. The completion word is a counter rather than a flag, so several transfers can share one counter and a consumer can wait until it reaches the expected total. The engine talks to local memory through a simple synchronous port with one cycle of read latency. It emits answers on a valid/ready output stream. While an answer is waiting on the output, it holds off the input stream and never loses a word.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, err_pulse and mem_en are all 0.
- R2: A deposit message is word 0 = PUT_CODE (default 32'hA1), word 1 = destination address, word 2 = length N, word 3 = counter address, then N data words. The data words are written to destination+0 .. destination+N-1 in arrival order. in_last marks the final word of the message.
- R3: After the final data word of a deposit has been written, the word at the counter address is read and written back plus one. If the counter address lies inside the destination block, the result is the newly written data plus one.
- R4: A deposit with N = 0 writes no data word and still adds one to the counter word.
- R5: A fetch message is word 0 = GET_CODE (default 32'hB2), word 1 = local source address, word 2 = length N, word 3 = requester buffer address, word 4 = requester counter address, word 5 = requester node (in_last on word 5). The answer is requester node, PUT_CODE, requester buffer address, N, requester counter address, then the N local words from source ascending, with out_last only on the final word.
- R6: A fetch with N = 0 is answered with the five header words alone, and out_last is set on the fifth.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold their values. in_ready stays 0 for as long as out_valid is 1, and every answer word is delivered exactly once.
- R8: A message whose word 0 matches neither code is consumed up to and including its in_last word. It causes no memory write and no output. err_pulse is high for one cycle, in the cycle after word 0 is accepted.
- R9: Counter updates accumulate: k deposits naming the same counter address raise it by exactly k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input message word |
| in_last | input | 1 | Final word of the input message |
| in_ready | output | 1 | Engine accepts the input word |
| out_valid | output | 1 | Answer word valid |
| out_data | output | 32 | Answer message word |
| out_last | output | 1 | Final word of the answer message |
| out_ready | input | 1 | Downstream accepts the answer word |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| err_pulse | output | 1 | One-cycle pulse for a dropped message |

## Verification
Two pairs of functions can collide. The first is the counter update and the data write of a deposit whose counter address sits inside its own destination block. The bench provokes this with a block whose third word is the counter, and judges it by requiring that word to end at the deposited value plus one. The second is an output stall coinciding with pending input: during every answer the bench stalls out_ready in several patterns while holding an unknown-code word valid on the input. It then requires in_ready to stay low, each stalled word to stay unchanged, and no error pulse to appear.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int WORD_W       = 32;
    localparam int IDX_W        = 3;
    localparam int PUT_HDR_LAST = 3;
    localparam int GET_HDR_LAST = 5;
    localparam int RPL_HDR_LAST = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_PUT,
        KIND_GET,
        KIND_BAD
    } kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_PUT_DATA,
        ST_FLAG_RD,
        ST_FLAG_WR,
        ST_DROP,
        ST_RPL_HDR,
        ST_RPL_RD,
        ST_RPL_LAT,
        ST_RPL_DATA
    } state_e;

    typedef struct packed {
        word_t addr;   // deposit destination or fetch source
        word_t len;
        word_t flag;   // local counter address (deposit)
        word_t raddr;  // requester buffer address (fetch)
        word_t rflag;  // requester counter address (fetch)
        word_t node;   // requester node (fetch)
    } hdr_t;

    function automatic kind_e classify(word_t code, word_t put_code, word_t get_code);
        if (code == put_code) return KIND_PUT;
        if (code == get_code) return KIND_GET;
        return KIND_BAD;
    endfunction

endpackage

// File: rtl/blkxfer_hdr.sv
module blkxfer_hdr
    import blkxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  take,
    input  kind_e kind,
    input  word_t word,
    output hdr_t  hdr,
    output logic  last_take
);

    idx_t idx;
    idx_t last_idx;

    always_comb begin
        last_idx = (kind == KIND_GET) ? idx_t'(GET_HDR_LAST) : idx_t'(PUT_HDR_LAST);
    end

    assign last_take = take && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            hdr <= '0;
        end else if (start) begin
            idx <= idx_t'(1);
        end else if (take) begin
            idx <= idx + 1'b1;
            case (idx)
                idx_t'(1): hdr.addr <= word;
                idx_t'(2): hdr.len  <= word;
                idx_t'(3): begin
                    if (kind == KIND_GET) hdr.raddr <= word;
                    else                  hdr.flag  <= word;
                end
                idx_t'(4): hdr.rflag <= word;
                idx_t'(5): hdr.node  <= word;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/blkxfer_walk.sv
module blkxfer_walk
    import blkxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    input  word_t base,
    input  word_t len,
    output word_t addr,
    output logic  at_last,
    output logic  done
);

    word_t base_q;
    word_t len_q;
    word_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= base;
            len_q  <= len;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + word_t'(1);
        end
    end

    assign addr    = base_q + cnt_q;
    assign at_last = (cnt_q + word_t'(1)) == len_q;
    assign done    = cnt_q == len_q;

endmodule

// File: rtl/blkxfer_reply_fmt.sv
module blkxfer_reply_fmt
    import blkxfer_pkg::*;
#(
    parameter word_t PUT_CODE = 32'h0000_00A1
) (
    input  idx_t  idx,
    input  word_t node,
    input  word_t raddr,
    input  word_t len,
    input  word_t rflag,
    output word_t word
);

    always_comb begin
        case (idx)
            idx_t'(0): word = node;
            idx_t'(1): word = PUT_CODE;
            idx_t'(2): word = raddr;
            idx_t'(3): word = len;
            default:   word = rflag;
        endcase
    end

endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
    import blkxfer_pkg::*;
#(
    parameter word_t PUT_CODE = 32'h0000_00A1,
    parameter word_t GET_CODE = 32'h0000_00B2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              err_pulse
);

    state_e state_q, state_d;
    kind_e  kind_q;
    kind_e  code_kind;
    idx_t   ridx_q, ridx_d;
    word_t  dq_q;
    logic   err_q;

    logic   in_fire, out_fire;
    logic   hdr_start, hdr_take, hdr_last;
    hdr_t   hdr;
    logic   walk_step;
    word_t  walk_addr;
    logic   walk_at_last, walk_done;
    word_t  fmt_word;
    logic   len_zero;

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign code_kind = classify(in_data, PUT_CODE, GET_CODE);
    assign len_zero  = (hdr.len == '0);

    assign hdr_start = (state_q == ST_IDLE) && in_fire &&
                       ((code_kind == KIND_PUT) || (code_kind == KIND_GET));
    assign hdr_take  = (state_q == ST_HDR) && in_fire;
    assign walk_step = ((state_q == ST_PUT_DATA) && in_fire) || (state_q == ST_RPL_LAT);

    blkxfer_hdr u_hdr (
        .clk       (clk),
        .rst       (rst),
        .start     (hdr_start),
        .take      (hdr_take),
        .kind      (kind_q),
        .word      (in_data),
        .hdr       (hdr),
        .last_take (hdr_last)
    );

    blkxfer_walk u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (hdr_last),
        .step    (walk_step),
        .base    (hdr.addr),
        .len     (hdr.len),
        .addr    (walk_addr),
        .at_last (walk_at_last),
        .done    (walk_done)
    );

    blkxfer_reply_fmt #(
        .PUT_CODE (PUT_CODE)
    ) u_fmt (
        .idx   (ridx_q),
        .node  (hdr.node),
        .raddr (hdr.raddr),
        .len   (hdr.len),
        .rflag (hdr.rflag),
        .word  (fmt_word)
    );

    // Stream handshakes
    always_comb begin
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_HDR) ||
                    (state_q == ST_PUT_DATA) || (state_q == ST_DROP);
        out_valid = (state_q == ST_RPL_HDR) || (state_q == ST_RPL_DATA);
        out_data  = (state_q == ST_RPL_HDR) ? fmt_word : dq_q;
        if (state_q == ST_RPL_HDR)
            out_last = (ridx_q == idx_t'(RPL_HDR_LAST)) && len_zero;
        else
            out_last = (state_q == ST_RPL_DATA) && walk_done;
    end

    // Memory port
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_PUT_DATA: begin
                mem_en    = in_fire;
                mem_we    = in_fire;
                mem_addr  = walk_addr;
                mem_wdata = in_data;
            end
            ST_FLAG_RD: begin
                mem_en   = 1'b1;
                mem_addr = hdr.flag;
            end
            ST_FLAG_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = hdr.flag;
                mem_wdata = mem_rdata + word_t'(1);
            end
            ST_RPL_RD: begin
                mem_en   = 1'b1;
                mem_addr = walk_addr;
            end
            default: ;
        endcase
    end

    // Sequencer
    always_comb begin
        state_d = state_q;
        ridx_d  = ridx_q;
        case (state_q)
            ST_IDLE: begin
                if (in_fire) begin
                    if (code_kind == KIND_BAD) state_d = in_last ? ST_IDLE : ST_DROP;
                    else                       state_d = ST_HDR;
                end
            end
            ST_HDR: begin
                if (hdr_last) begin
                    if (kind_q == KIND_GET) begin
                        state_d = ST_RPL_HDR;
                        ridx_d  = '0;
                    end else begin
                        state_d = len_zero ? ST_FLAG_RD : ST_PUT_DATA;
                    end
                end
            end
            ST_PUT_DATA: begin
                if (in_fire && walk_at_last) state_d = ST_FLAG_RD;
            end
            ST_FLAG_RD: state_d = ST_FLAG_WR;
            ST_FLAG_WR: state_d = ST_IDLE;
            ST_DROP: begin
                if (in_fire && in_last) state_d = ST_IDLE;
            end
            ST_RPL_HDR: begin
                if (out_fire) begin
                    if (ridx_q == idx_t'(RPL_HDR_LAST)) state_d = len_zero ? ST_IDLE : ST_RPL_RD;
                    else                                 ridx_d  = ridx_q + 1'b1;
                end
            end
            ST_RPL_RD:  state_d = ST_RPL_LAT;
            ST_RPL_LAT: state_d = ST_RPL_DATA;
            ST_RPL_DATA: begin
                if (out_fire) state_d = walk_done ? ST_IDLE : ST_RPL_RD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
            ridx_q  <= '0;
            dq_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ridx_q  <= ridx_d;
            err_q   <= (state_q == ST_IDLE) && in_fire && (code_kind == KIND_BAD);
            if (hdr_start)               kind_q <= code_kind;
            if (state_q == ST_RPL_LAT)   dq_q   <= mem_rdata;
        end
    end

    assign err_pulse = err_q;

endmodule

// File: rtl/blkxfer_engine_chk.sv
module blkxfer_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        out_ready,
    input logic        mem_en,
    input logic        mem_we,
    input logic        err_pulse
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (in_ready && !out_valid && !err_pulse && !mem_en)); // R1

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

    AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R7

    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(in_valid && in_ready)); // R8

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !(mem_en && mem_we)); // R8

endmodule

bind blkxfer_engine blkxfer_engine_chk i_chk (.*);

// File: tb/test_blkxfer_engine.sv
`timescale 1ns/100ps
module test_blkxfer_engine;

    localparam logic [31:0] PUT_C = 32'h0000_00A1;
    localparam logic [31:0] GET_C = 32'h0000_00B2;
    localparam logic [31:0] BAD_C = 32'h0000_0077;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_ready = 1'b0;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        err_pulse;

    logic [31:0] mem   [256];
    logic [31:0] model [256];

    int checks = 0;
    int fails  = 0;
    int err_cnt = 0;
    int stray_out = 0;
    bit in_recv = 0;

    always #2.5 clk = ~clk;

    blkxfer_engine #(.PUT_CODE(PUT_C), .GET_CODE(GET_C)) i_blkxfer_engine (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .err_pulse(err_pulse)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    always @(negedge clk) begin
        if (!rst && err_pulse) err_cnt++;
        if (!rst && out_valid && !in_recv) stray_out++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic send_word(input logic [31:0] w, input bit l);
        in_valid = 1'b1; in_data = w; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_image(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== model[i]) bad = i;
        if (bad < 0) chk(1'b1, req, "memory image", 0, 0);
        else chk(1'b0, req, $sformatf("memory word %0d", bad), mem[bad], model[bad]);
    endtask

    task automatic put_msg(input int dest, input int len, input int flag, input int seed, input string req);
        send_word(PUT_C, 1'b0);
        send_word(32'(dest), 1'b0);
        send_word(32'(len), 1'b0);
        send_word(32'(flag), len == 0);
        for (int i = 0; i < len; i++) begin
            send_word(32'(seed * 256 + i), i == len - 1);
            model[(dest + i) % 256] = 32'(seed * 256 + i);
        end
        model[flag % 256] = model[flag % 256] + 1;
        settle();
        cmp_image(req);
        chk(mem[flag % 256] === model[flag % 256], "R3", "counter word", mem[flag % 256], model[flag % 256]);
    endtask

    task automatic get_msg(input int src, input int len, input int rdest, input int rflag,
                           input int node, input int mode);
        logic [31:0] exp_w [16];
        int n = 5 + len;
        int got = 0;
        int cyc = 0;
        int errs0;
        bit held = 0;
        logic [31:0] held_d;
        logic held_l;
        exp_w[0] = 32'(node); exp_w[1] = PUT_C; exp_w[2] = 32'(rdest);
        exp_w[3] = 32'(len);  exp_w[4] = 32'(rflag);
        for (int i = 0; i < len; i++) exp_w[5 + i] = model[(src + i) % 256];
        send_word(GET_C, 1'b0);
        send_word(32'(src), 1'b0);
        send_word(32'(len), 1'b0);
        send_word(32'(rdest), 1'b0);
        send_word(32'(rflag), 1'b0);
        errs0 = err_cnt;
        in_recv = 1;
        send_word(32'(node), 1'b1);
        while (got < n) begin
            @(negedge clk);
            cyc++;
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 2) == 0;
                default: out_ready = (cyc % 3) == 2;
            endcase
            in_valid = 1'b1; in_data = BAD_C; in_last = 1'b1;
            if (out_valid)
                chk(in_ready == 1'b0, "R7", "in_ready during answer", in_ready, 0);
            if (held) begin
                chk(out_valid === 1'b1 && out_data === held_d && out_last === held_l, "R7",
                    "stalled word held", out_data, held_d);
            end
            held   = out_valid && !out_ready;
            held_d = out_data;
            held_l = out_last;
            if (out_valid && out_ready) begin
                chk(out_data === exp_w[got], (got < 5 && len == 0) ? "R6" : "R5",
                    $sformatf("answer word %0d", got), out_data, exp_w[got]);
                chk(out_last === (got == n - 1), (len == 0) ? "R6" : "R5",
                    $sformatf("out_last at word %0d", got), out_last, got == n - 1);
                got++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
        in_recv = 0;
        repeat (3) @(negedge clk);
        chk(stray_out == 0, "R5", "no extra answer words", stray_out, 0);
        chk(err_cnt == errs0, "R7", "held input word not taken", err_cnt, errs0);
        cmp_image("R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        summary();
        $finish;
    end

    initial begin
        int e0;
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 32'(i * 7 + 3);
            model[i] = 32'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1", "in_ready", in_ready, 1);
        chk(out_valid === 1'b0, "R1", "out_valid", out_valid, 0);
        chk(err_pulse === 1'b0, "R1", "err_pulse", err_pulse, 0);
        chk(mem_en === 1'b0, "R1", "mem_en", mem_en, 0);

        // R2/R4/R9: deposit length sweep, all sharing counter word 200
        for (int l = 0; l <= 6; l++)
            put_msg(16 * l + 1, l, 200, l + 1, (l == 0) ? "R4" : "R2");
        chk(mem[200] === 32'(200 * 7 + 3 + 7), "R9", "shared counter total", mem[200], 200 * 7 + 3 + 7);

        // R3: counter inside destination block
        put_msg(120, 4, 122, 9, "R3");
        chk(mem[122] === 32'(9 * 256 + 2 + 1), "R3", "counter in block", mem[122], 9 * 256 + 3);

        // R8: unknown codes
        e0 = err_cnt;
        send_word(BAD_C, 1'b0);
        send_word(PUT_C, 1'b0);
        send_word(32'd50, 1'b0);
        send_word(32'd0, 1'b1);
        settle();
        chk(err_cnt == e0 + 1, "R8", "one error pulse", err_cnt, e0 + 1);
        chk(stray_out == 0, "R8", "no output for dropped", stray_out, 0);
        cmp_image("R8");
        send_word(BAD_C, 1'b1);
        settle();
        chk(err_cnt == e0 + 2, "R8", "single-word drop pulse", err_cnt, e0 + 2);
        cmp_image("R8");
        put_msg(210, 2, 215, 11, "R8");

        // R5/R6/R7: fetch length sweep under three stall patterns
        for (int m = 0; m < 3; m++)
            for (int l = 0; l <= 5; l++)
                get_msg(16 * l + 1, l, 1000 + l, 2000 + m, 40 + m, m);

        summary();
        $finish;
    end

endmodule